// File: doc/BRIEF.md
# MDIO Management Master with Single Command Register

This block runs Clause-22 management frames towards an Ethernet PHY. It has one
32-bit command/status word. The host starts a whole transaction by writing that word once.
The word carries an operation code, a PHY address, a register address and 16 data bits.
The block then builds a 64-bit frame and shifts it out on a divided management clock.
For a read, it releases the data line during the turnaround and data phase and samples
the PHY's reply on each rising clock edge.

When the frame ends, the ready flag in the same word sets again. For a read, the 16-bit
data field is replaced by the captured value. A single-cycle done event, meant for the
interrupt logic, fires in the same cycle. While a frame is running, further host writes
are dropped, so software polls the ready flag before it issues the next command.

Top module: `mdio_ctl_master`

## Requirements
- R1: After reset the command word reads 0x1000_0000, which means ready (bit 28) is 1 and every other bit is 0. In the same state mdc, mdio_oe and done_evt are 0.
- R2: A write while ready is 1 latches the fields. The layout is data in bits 15:0, register address in bits 20:16, PHY address in bits 25:21 and opcode in bits 27:26. Ready reads 0 from the cycle after the write.
- R3: The frame is sent MSB first in this order: 32 ones, the start pattern 0 then 1, two opcode bits, five PHY-address bits, five register-address bits, a two-bit turnaround, and 16 data bits. For non-read frames the turnaround is 1 then 0. mdio_o changes only in the cycle where mdc falls, or when a frame is launched.
- R4: mdc has a period of 2*HALF_DIV clock cycles while a frame runs, and it stays low while ready is 1.
- R5: Opcode 2 is a read. mdio_oe is 0 from turnaround bit 46 to the end of the frame. mdio_i is sampled at each rising mdc edge of the 16 data bits. At completion, bits 15:0 hold the sampled value, first sample in bit 15.
- R6: Ready returns to 1 exactly 128*HALF_DIV cycles after the clock edge that accepted the write. done_evt is high for that one cycle only.
- R7: A write while ready is 0 is ignored. The fields, the frame on the wire and the completion time are all unchanged.
- R8: Opcodes 0, 1 and 3 all send a driven frame with turnaround 1 then 0 and the written data. Opcode 1 is the write operation.
- R9: After a non-read frame, bits 15:0 still hold the data that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host write strobe for the command word |
| reg_wr_data | input | 32 | Host write data |
| reg_rd_data | output | 32 | Current command/status word |
| done_evt | output | 1 | One-cycle completion event |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench drives inputs on falling clock edges and counts falling edges from the edge that accepted a write. Ready must read 0 on the first count. Ready and done_evt must both appear on count 128*HALF_DIV, and done_evt must be gone on the next count. A bench PHY model counts mdc rising edges modulo 64 to rebuild each frame and to answer reads after mdc falls. Frame contents and the captured read data are compared only after ready returns.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_BITS  = 5;
  localparam int DATA_BITS  = 16;
  localparam int OP_BITS    = 2;
  localparam int FRAME_BITS = PRE_BITS + 2 + OP_BITS + 2 * ADDR_BITS + 2 + DATA_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = PRE_BITS + 2 + OP_BITS + 2 * ADDR_BITS;
  localparam int DATA_IDX   = TA_IDX + 2;
  localparam int READY_BIT  = 28;

  typedef enum logic [OP_BITS-1:0] {
    OPC_RSV0 = 2'd0,
    OPC_WR   = 2'd1,
    OPC_RD   = 2'd2,
    OPC_RSV3 = 2'd3
  } mgmt_op_e;

  typedef struct packed {
    logic [OP_BITS-1:0]   op;
    logic [ADDR_BITS-1:0] phy;
    logic [ADDR_BITS-1:0] regad;
    logic [DATA_BITS-1:0] data;
  } ctrl_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input ctrl_t c);
    logic [1:0] ta;
    ta = (c.op == OPC_RD) ? 2'b11 : 2'b10;
    return {{PRE_BITS{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, c.data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  logic edge_due;

  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign edge_due = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt == CW'(HALF_DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign edge_due = run && (cnt == CW'(HALF_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run) mdc <= 1'b0;
    else if (edge_due) mdc <= ~mdc;
  end

  assign rise_stb = edge_due && !mdc;
  assign fall_stb = edge_due && mdc;

  a_r4_stopped_clock_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  ctrl_t                cmd,
  input  logic                 rise_stb,
  input  logic                 fall_stb,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 finish,
  output logic [DATA_BITS-1:0] rdata
);
  logic [FRAME_BITS-1:0] sreg;
  logic [IDX_W-1:0]      idx;
  logic                  is_rd;
  logic [DATA_BITS-1:0]  cap;

  assign finish = busy && fall_stb && (idx == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      mdio_oe <= 1'b0;
      cap     <= '0;
    end else if (start && !busy) begin
      sreg    <= build_frame(cmd);
      idx     <= '0;
      busy    <= 1'b1;
      is_rd   <= (cmd.op == OPC_RD);
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_stb && is_rd && idx >= IDX_W'(DATA_IDX))
        cap <= {cap[DATA_BITS-2:0], mdio_i};
      if (finish) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
      end else if (fall_stb) begin
        idx  <= idx + 1'b1;
        sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
        if (is_rd && (idx + 1'b1) == IDX_W'(TA_IDX)) mdio_oe <= 1'b0;
      end
    end
  end

  assign mdio_o = sreg[FRAME_BITS-1];
  assign rdata  = cap;

  a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && idx >= IDX_W'(TA_IDX)) |-> !mdio_oe);
  a_r8_driven_frame: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_rd) |-> mdio_oe);
  a_r3_idx_steps_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall_stb && !start) |=> $stable(idx));
endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  output logic        done_evt,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  ready_q;
  logic  launch, seq_busy, seq_fin, rise_stb, fall_stb;
  logic [DATA_BITS-1:0] seq_rdata;

  assign launch = reg_wr_en && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      ready_q  <= 1'b1;
      done_evt <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      if (launch) begin
        ctrl_q  <= ctrl_t'(reg_wr_data[CTRL_W-1:0]);
        ready_q <= 1'b0;
      end else if (seq_fin) begin
        ready_q  <= 1'b1;
        done_evt <= 1'b1;
        if (ctrl_q.op == OPC_RD) ctrl_q.data <= seq_rdata;
      end
    end
  end

  assign reg_rd_data = {3'b000, ready_q, ctrl_q};

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk      (clk),
    .rst      (rst),
    .run      (seq_busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (launch),
    .cmd      (ctrl_t'(reg_wr_data[CTRL_W-1:0])),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (seq_busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .finish   (seq_fin),
    .rdata    (seq_rdata)
  );

  a_r2_launch_clears_ready: assert property (@(posedge clk) disable iff (rst)
    launch |=> !ready_q);
  a_r7_busy_write_keeps_fields: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !ready_q) |=> $stable(reg_rd_data[27:16]));
  a_r7_busy_write_no_restart: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !ready_q && !seq_fin) |=> !ready_q);
  a_r6_done_marks_ready_rise: assert property (@(posedge clk) disable iff (rst)
    done_evt |-> (ready_q && !$past(ready_q)));
  a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> !mdc);
  a_r6_busy_excludes_ready: assert property (@(posedge clk) disable iff (rst)
    seq_busy |-> !ready_q);
  a_r3_data_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> ($fell(mdc) || $fell(ready_q)));
endmodule

// File: tb/mdio_ctl_master_tb_top.sv
module mdio_ctl_master_tb_top;
  localparam int HALF    = 2;
  localparam int EXP_CYC = 128 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic done_evt, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mdio_ctl_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .done_evt(done_evt), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // PHY model: counts rising mdc edges modulo 64 per frame
  logic [5:0]  rcnt = '0;
  logic [63:0] seen = '0;
  logic        cur_rd = 1'b0;
  logic [15:0] cur_resp = '0;
  int          oe_viol = 0;

  always @(posedge mdc) begin
    seen <= {seen[62:0], mdio_o};
    if (cur_rd && rcnt >= 6'd46 && mdio_oe) oe_viol <= oe_viol + 1;
    rcnt <= rcnt + 6'd1;
  end

  always @(negedge mdc) begin
    if (cur_rd && rcnt == 6'd47) mdio_i = 1'b0;
    else if (cur_rd && rcnt >= 6'd48) mdio_i = cur_resp[6'd63 - rcnt];
    else mdio_i = 1'b1;
  end

  function automatic logic [15:0] resp_of(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h2D} ^ 16'h3C5A;
  endfunction

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, p, r, 2'b10, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] d, input bit poke);
    int n;
    int viol0;
    logic [31:0] word;
    logic [63:0] ef;
    logic [31:0] exp_word;
    word = {4'b0, op, p, r, d};
    cur_rd = (op == 2'd2);
    cur_resp = resp_of(p, r);
    viol0 = oe_viol;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = word;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk(reg_rd_data[28] == 1'b0, "R2 ready cleared", 64'(reg_rd_data[28]), 64'd0);
    chk(reg_rd_data[27:0] == word[27:0], "R2 fields latched", 64'(reg_rd_data), 64'(word));
    n = 0;
    while (reg_rd_data[28] == 1'b0 && n < EXP_CYC + 20) begin
      if (poke && n == 10) begin
        reg_wr_en = 1'b1; reg_wr_data = ~word;
      end else begin
        reg_wr_en = 1'b0;
      end
      if (poke && n == 12)
        chk(reg_rd_data[28:16] == {1'b0, word[27:16]}, "R7 busy write ignored",
            64'(reg_rd_data[28:16]), 64'({1'b0, word[27:16]}));
      @(negedge clk);
      n++;
    end
    reg_wr_en = 1'b0;
    chk(n == EXP_CYC, "R6 completion cycle", 64'(n), 64'(EXP_CYC));
    chk(done_evt == 1'b1, "R6 done with ready", 64'(done_evt), 64'd1);
    ef = exp_frame(op, p, r, d);
    exp_word = {3'b0, 1'b1, op, p, r, (op == 2'd2) ? resp_of(p, r) : d};
    if (op == 2'd2) begin
      chk(seen[63:18] == ef[63:18], "R3 read frame header", seen >> 18, ef >> 18);
      chk(oe_viol == viol0, "R5 line released", 64'(oe_viol - viol0), 64'd0);
      chk(reg_rd_data == exp_word, "R5 read data", 64'(reg_rd_data), 64'(exp_word));
    end else begin
      chk(seen == ef, "R3 R8 driven frame", seen, ef);
      chk(reg_rd_data == exp_word, "R9 data kept", 64'(reg_rd_data), 64'(exp_word));
    end
    @(negedge clk);
    chk(done_evt == 1'b0, "R6 done one cycle", 64'(done_evt), 64'd0);
    chk(mdc == 1'b0, "R4 mdc idle low", 64'(mdc), 64'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(reg_rd_data == 32'h1000_0000, "R1 reset word", 64'(reg_rd_data), 64'h1000_0000);
    chk({mdc, mdio_oe, done_evt} == 3'b000, "R1 reset outputs",
        64'({mdc, mdio_oe, done_evt}), 64'd0);
    // directed corners
    txn(2'd1, 5'd31, 5'd31, 16'hFFFF, 1'b0);
    txn(2'd1, 5'd0, 5'd0, 16'h0000, 1'b0);
    txn(2'd2, 5'd31, 5'd0, 16'h1234, 1'b0);
    txn(2'd2, 5'd5, 5'd17, 16'hBEEF, 1'b1);
    txn(2'd1, 5'd9, 5'd3, 16'hA55A, 1'b1);
    txn(2'd3, 5'd1, 5'd2, 16'h8001, 1'b0);
    txn(2'd0, 5'd4, 5'd8, 16'h7FFE, 1'b0);
    // constrained random mix, mostly reads and writes
    for (int i = 0; i < 20; i++) begin
      logic [1:0] op;
      int sel;
      sel = $urandom_range(0, 9);
      op = (sel < 4) ? 2'd1 : (sel < 8) ? 2'd2 : 2'($urandom_range(0, 3));
      txn(op, 5'($urandom), 5'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0));
    end
    finish_run();
  end
endmodule